// File: doc/BRIEF.md
# Memory Module Parameter Image Builder

This block turns a requested memory technology (single data rate, double data rate, or second-generation double data rate) and a module capacity in megabytes into a 64-byte module parameter image. The image is the kind a memory controller's boot code reads to learn a module's geometry. A one-cycle start pulse latches the two inputs. The block then works through the following steps, one step per clock:

- It rounds the capacity down to a power of two.
- It may fall back to an older technology if the size is too small for the one requested.
- It spreads the capacity across up to eight banks within per-technology limits.
- It folds a density code.
- It fills an internal 64-entry byte store.
- It accumulates and stores a checksum in the last byte.

Once `done` has pulsed, any byte of the image can be read back through a registered read port. A `fault` flag reports a request that cannot be built. A `trim` flag reports that the capacity could not be represented exactly.

Top module: `spd_param_gen`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `trim` are all 0.
- R2: A request with capacity below 4 MB, or with technology code 3, sets `fault` and pulses `done` two clocks after start. Nothing is written, so a previously built image reads back unchanged. `trim` stays 0.
- R3: The capacity is cut to the largest power of two not above it, giving log size L. `trim` is set when the cut removed any bits.
- R4: Technology codes are 0 for single rate, 1 for double rate and 2 for second-generation. Their log-size windows (min..max) are 2..9, 5..12 and 7..14. If L is below the window minimum, the technology becomes double rate when L is at least 5, and single rate otherwise. Byte 2 holds the final technology as 4, 7 or 8 respectively.
- R5: The bank count starts at 1. Each clock where L exceeds the window maximum and banks is below 8, L drops by one and banks rises by one. `trim` is set if (2^L)·banks is then smaller than the power-of-two capacity.
- R6: After that loop, a single bank with L above the window minimum becomes two banks with L reduced by one.
- R7: Byte 31 holds the density code, where d = 2^(L−2). For second-generation parts the code is (d & 0xE0) | ((d>>8) & 0x1F). For double rate it is (d & 0xF8) | ((d>>8) & 0x07). For single rate it is d & 0xFF.
- R8: Byte 5 holds banks−1 for second-generation parts and banks otherwise.
- R9: Fixed bytes are 0:128, 1:8, 3:13, 4:10, 6:64, 8:4, 9:0x25, 10:1, 12:0x82, 13:8, 16:12, 17:4, 18:12, 20:2, 23:0x12, 27:20, 28:15, 29:20, 30:45, 32:20, 33:8, 34:20 and 35:8. Bytes 15 and 19 are 0 for second-generation parts and 1 otherwise. Every other byte below 63 is 0.
- R10: Byte 63 is the sum modulo 256 of bytes 0 to 62.
- R11: `busy` rises the clock after an accepted start. `done` is a one-clock pulse with `busy` low, arriving 130+S clocks after start, where S is the number of R5 loop steps.
- R12: A start pulse while `busy` is high is ignored. The running build finishes with its own latched inputs and timing.
- R13: Byte k of the image appears on `rd_data` one clock after `rd_addr` is set to k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request pulse, taken when idle |
| mem_kind | input | 2 | Technology code (0, 1, 2; 3 is rejected) |
| size_mb | input | SIZE_W | Module capacity in megabytes |
| rd_addr | input | 6 | Image byte index to read |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-clock completion pulse |
| fault | output | 1 | Last request was rejected |
| trim | output | 1 | Last capacity was rounded or not fully covered |
| rd_data | output | 8 | Image byte, registered |

## Verification
The assertions assume that `start` is held for a single clock and that any start raised during a build is ignored rather than queued. They also assume the flags move only at the start of a request and during its build. The stimulus drives every start as a one-clock pulse on the falling edge. It deliberately adds one extra pulse in the middle of a build to exercise the ignore rule. Random capacities are drawn by first choosing a log size from 0 to 19 and then filling the bits below it, so that every window, both fallbacks, the bank loop limit and the sub-4 MB rejection all occur.

// File: rtl/spd_gen_pkg.sv
package spd_gen_pkg;

   localparam int IMG_BYTES = 64;
   localparam int IMG_AW    = 6;
   localparam int LOG_W     = 5;
   localparam int LAST_DATA = IMG_BYTES - 2;
   localparam int CSUM_IDX  = IMG_BYTES - 1;

   typedef enum logic [1:0] {
      KIND_SDR  = 2'd0,
      KIND_DDR  = 2'd1,
      KIND_DDR2 = 2'd2,
      KIND_BAD  = 2'd3
   } mem_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NORM,
      ST_SPLIT,
      ST_FORCE,
      ST_FILL,
      ST_SUM
   } build_st_e;

   function automatic logic [LOG_W-1:0] kind_min(mem_kind_e k);
      case (k)
         KIND_DDR:  return LOG_W'(5);
         KIND_DDR2: return LOG_W'(7);
         default:   return LOG_W'(2);
      endcase
   endfunction

   function automatic logic [LOG_W-1:0] kind_max(mem_kind_e k);
      case (k)
         KIND_DDR:  return LOG_W'(12);
         KIND_DDR2: return LOG_W'(14);
         default:   return LOG_W'(9);
      endcase
   endfunction

   function automatic logic [7:0] kind_code(mem_kind_e k);
      case (k)
         KIND_DDR:  return 8'd7;
         KIND_DDR2: return 8'd8;
         default:   return 8'd4;
      endcase
   endfunction

endpackage

// File: rtl/spd_size_norm.sv
module spd_size_norm
   import spd_gen_pkg::*;
#(
   parameter int SIZE_W = 20
) (
   input  mem_kind_e          kind_in,
   input  logic [SIZE_W-1:0]  size_in,
   output logic [LOG_W-1:0]   log_size,
   output logic               cut,
   output logic               reject,
   output mem_kind_e          kind_eff
);

   logic [SIZE_W-1:0] pow_size;

   always_comb begin
      log_size = '0;
      for (int i = 0; i < SIZE_W; i++) begin
         if (size_in[i]) log_size = LOG_W'(i);
      end
      pow_size = SIZE_W'(1) << log_size;
      cut      = (size_in != pow_size);
      reject   = (size_in < SIZE_W'(4)) || (kind_in == KIND_BAD);
      kind_eff = kind_in;
      if (log_size < kind_min(kind_in)) begin
         kind_eff = (log_size >= LOG_W'(5)) ? KIND_DDR : KIND_SDR;
      end
   end

endmodule

// File: rtl/spd_byte_src.sv
module spd_byte_src
   import spd_gen_pkg::*;
(
   input  logic [IMG_AW-1:0] idx,
   input  mem_kind_e         kind,
   input  logic [3:0]        banks,
   input  logic [LOG_W-1:0]  log_size,
   output logic [7:0]        value
);

   logic [15:0] dens_raw;
   logic [7:0]  dens_code;
   logic [7:0]  ddr2_flag;

   always_comb begin
      dens_raw = 16'd1 << (log_size - LOG_W'(2));
      case (kind)
         KIND_DDR2: dens_code = (dens_raw[7:0] & 8'hE0) | (dens_raw[15:8] & 8'h1F);
         KIND_DDR:  dens_code = (dens_raw[7:0] & 8'hF8) | (dens_raw[15:8] & 8'h07);
         default:   dens_code = dens_raw[7:0];
      endcase
      ddr2_flag = (kind == KIND_DDR2) ? 8'd0 : 8'd1;
   end

   always_comb begin
      case (idx)
         6'd0:  value = 8'd128;
         6'd1:  value = 8'd8;
         6'd2:  value = kind_code(kind);
         6'd3:  value = 8'd13;
         6'd4:  value = 8'd10;
         6'd5:  value = (kind == KIND_DDR2) ? {4'd0, banks - 4'd1} : {4'd0, banks};
         6'd6:  value = 8'd64;
         6'd8:  value = 8'd4;
         6'd9:  value = 8'h25;
         6'd10: value = 8'd1;
         6'd12: value = 8'h82;
         6'd13: value = 8'd8;
         6'd15: value = ddr2_flag;
         6'd16: value = 8'd12;
         6'd17: value = 8'd4;
         6'd18: value = 8'd12;
         6'd19: value = ddr2_flag;
         6'd20: value = 8'd2;
         6'd23: value = 8'h12;
         6'd27: value = 8'd20;
         6'd28: value = 8'd15;
         6'd29: value = 8'd20;
         6'd30: value = 8'd45;
         6'd31: value = dens_code;
         6'd32: value = 8'd20;
         6'd33: value = 8'd8;
         6'd34: value = 8'd20;
         6'd35: value = 8'd8;
         default: value = 8'd0;
      endcase
   end

endmodule

// File: rtl/spd_img_ram.sv
module spd_img_ram #(
   parameter int DEPTH   = 64,
   parameter int DW      = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] iaddr,
   output logic [DW-1:0] idata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign idata = mem[iaddr];

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_comb_out
         assign rdata = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/spd_param_gen.sv
module spd_param_gen
   import spd_gen_pkg::*;
#(
   parameter int SIZE_W    = 20,
   parameter int MAX_BANKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mem_kind,
   input  logic [SIZE_W-1:0] size_mb,
   input  logic [5:0]        rd_addr,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic              trim,
   output logic [7:0]        rd_data
);

   localparam int CAP_W = SIZE_W + 4;

   generate
      if (SIZE_W < 6 || SIZE_W > 31) begin : g_bad_size_w
         $error("SIZE_W must lie in 6..31");
      end
      if (MAX_BANKS < 2 || MAX_BANKS > 15) begin : g_bad_banks
         $error("MAX_BANKS must lie in 2..15");
      end
   endgenerate

   build_st_e          st_q;
   mem_kind_e          kind_q;
   logic [SIZE_W-1:0]  size_q;
   logic [LOG_W-1:0]   l_q;
   logic [LOG_W-1:0]   l0_q;
   logic [3:0]         banks_q;
   logic [IMG_AW-1:0]  idx_q;
   logic [7:0]         sum_q;

   logic [LOG_W-1:0]   norm_log;
   logic               norm_cut;
   logic               norm_reject;
   mem_kind_e          norm_kind;

   logic [7:0]         fill_byte;
   logic [7:0]         ram_idata;
   logic               ram_we;
   logic [IMG_AW-1:0]  ram_waddr;
   logic [7:0]         ram_wdata;

   logic [CAP_W-1:0]   cap_now;
   logic [CAP_W-1:0]   cap_need;
   logic               can_split;

   spd_size_norm #(.SIZE_W(SIZE_W)) u_norm (
      .kind_in  (kind_q),
      .size_in  (size_q),
      .log_size (norm_log),
      .cut      (norm_cut),
      .reject   (norm_reject),
      .kind_eff (norm_kind)
   );

   spd_byte_src u_bytes (
      .idx      (idx_q),
      .kind     (kind_q),
      .banks    (banks_q),
      .log_size (l_q),
      .value    (fill_byte)
   );

   spd_img_ram #(.DEPTH(IMG_BYTES), .DW(8), .REG_OUT(1'b1)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .iaddr (idx_q),
      .idata (ram_idata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_comb begin
      cap_now   = (CAP_W'(1) << l_q) * CAP_W'(banks_q);
      cap_need  = CAP_W'(1) << l0_q;
      can_split = (l_q > kind_max(kind_q)) && (banks_q < 4'(MAX_BANKS));
   end

   always_comb begin
      ram_we    = 1'b0;
      ram_waddr = idx_q;
      ram_wdata = fill_byte;
      if (st_q == ST_FILL) begin
         ram_we = 1'b1;
      end else if (st_q == ST_SUM && idx_q == IMG_AW'(LAST_DATA)) begin
         ram_we    = 1'b1;
         ram_waddr = IMG_AW'(CSUM_IDX);
         ram_wdata = sum_q + ram_idata;
      end
   end

   assign busy = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= KIND_SDR;
         size_q  <= '0;
         l_q     <= '0;
         l0_q    <= '0;
         banks_q <= 4'd1;
         idx_q   <= '0;
         sum_q   <= '0;
         done    <= 1'b0;
         fault   <= 1'b0;
         trim    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  kind_q <= mem_kind_e'(mem_kind);
                  size_q <= size_mb;
                  fault  <= 1'b0;
                  trim   <= 1'b0;
                  st_q   <= ST_NORM;
               end
            end
            ST_NORM: begin
               if (norm_reject) begin
                  fault <= 1'b1;
                  done  <= 1'b1;
                  st_q  <= ST_IDLE;
               end else begin
                  kind_q  <= norm_kind;
                  l_q     <= norm_log;
                  l0_q    <= norm_log;
                  trim    <= norm_cut;
                  banks_q <= 4'd1;
                  st_q    <= ST_SPLIT;
               end
            end
            ST_SPLIT: begin
               if (can_split) begin
                  l_q     <= l_q - LOG_W'(1);
                  banks_q <= banks_q + 4'd1;
               end else begin
                  if (cap_now < cap_need) trim <= 1'b1;
                  st_q <= ST_FORCE;
               end
            end
            ST_FORCE: begin
               if (banks_q == 4'd1 && l_q > kind_min(kind_q)) begin
                  l_q     <= l_q - LOG_W'(1);
                  banks_q <= 4'd2;
               end
               idx_q <= '0;
               st_q  <= ST_FILL;
            end
            ST_FILL: begin
               if (idx_q == IMG_AW'(LAST_DATA)) begin
                  idx_q <= '0;
                  sum_q <= '0;
                  st_q  <= ST_SUM;
               end else begin
                  idx_q <= idx_q + IMG_AW'(1);
               end
            end
            ST_SUM: begin
               sum_q <= sum_q + ram_idata;
               if (idx_q == IMG_AW'(LAST_DATA)) begin
                  idx_q <= '0;
                  done  <= 1'b1;
                  st_q  <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + IMG_AW'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spd_param_gen_chk.sv
module spd_param_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       fault,
   input logic       trim,
   input logic [3:0] banks
);

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_fault_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> done);

   assert_fault_no_trim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !trim);

   assert_start_ignored_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done));

   assert_flags_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(fault) && $stable(trim)));

   assert_bank_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (banks >= 4'd1) && (banks <= 4'd8));

endmodule

bind spd_param_gen spd_param_gen_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .fault (fault),
   .trim  (trim),
   .banks (banks_q)
);

// File: tb/spd_param_gen_test.sv
module spd_param_gen_test;

   localparam int SW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mem_kind = '0;
   logic [SW-1:0] size_mb = '0;
   logic [5:0]    rd_addr = '0;
   logic          busy, done, fault, trim;
   logic [7:0]    rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   logic [7:0] last_img [64];
   bit         have_img = 1'b0;

   spd_param_gen #(.SIZE_W(SW), .MAX_BANKS(8)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_kind(mem_kind),
      .size_mb(size_mb), .rd_addr(rd_addr), .busy(busy), .done(done),
      .fault(fault), .trim(trim), .rd_data(rd_data)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail   = n_fail + 1;
         n_checks = n_checks + 1;
         $display("FAIL R11 watchdog expired: actual=%0d cycles expected<150000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic chk(string req, int actual, int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   // Reference model of the requirement text
   function automatic void model(input int kind_in, input int size,
                                 output int kind, output int lg, output int banks,
                                 output int trim_e, output int fault_e, output int steps);
      int l0;
      int kmin, kmax;
      kind = kind_in; lg = 0; banks = 1; trim_e = 0; fault_e = 0; steps = 0;
      if (size < 4 || kind_in == 3) begin
         fault_e = 1;
         return;
      end
      for (int i = 0; i < SW; i++) if ((size >> i) & 1) lg = i;
      if (size != (1 << lg)) trim_e = 1;
      kmin = (kind == 1) ? 5 : (kind == 2) ? 7 : 2;
      if (lg < kmin) kind = (lg >= 5) ? 1 : 0;
      kmin = (kind == 1) ? 5 : (kind == 2) ? 7 : 2;
      kmax = (kind == 1) ? 12 : (kind == 2) ? 14 : 9;
      l0 = lg;
      while (lg > kmax && banks < 8) begin
         lg--; banks++; steps++;
      end
      if ((longint'(1) << l0) > (longint'(1) << lg) * banks) trim_e = 1;
      if (banks == 1 && lg > kmin) begin
         lg--; banks = 2;
      end
   endfunction

   function automatic int exp_byte(int idx, int kind, int lg, int banks);
      int d;
      d = 1 << (lg - 2);
      case (idx)
         0: return 128;  1: return 8;
         2: return (kind == 1) ? 7 : (kind == 2) ? 8 : 4;
         3: return 13;   4: return 10;
         5: return (kind == 2) ? banks - 1 : banks;
         6: return 64;   8: return 4;   9: return 'h25;  10: return 1;
         12: return 'h82; 13: return 8;
         15, 19: return (kind == 2) ? 0 : 1;
         16: return 12;  17: return 4;  18: return 12;  20: return 2;
         23: return 'h12; 27: return 20; 28: return 15; 29: return 20;
         30: return 45;
         31: begin
            if (kind == 2) return (d & 'hE0) | ((d >> 8) & 'h1F);
            if (kind == 1) return (d & 'hF8) | ((d >> 8) & 'h07);
            return d & 'hFF;
         end
         32: return 20;  33: return 8;  34: return 20;  35: return 8;
         default: return 0;
      endcase
   endfunction

   task automatic read_byte(int idx, output int val);
      @(negedge clk) rd_addr = 6'(idx);
      @(negedge clk) val = int'(rd_data);
   endtask

   task automatic run(int kind_in, int size, bit inject);
      int k, lg, b, te, fe, s, cycles, v, sum, e;
      string tag;
      model(kind_in, size, k, lg, b, te, fe, s);
      @(negedge clk);
      start = 1'b1; mem_kind = 2'(kind_in); size_mb = SW'(size);
      @(negedge clk);
      start = 1'b0;
      chk("R11 busy after start", int'(busy), 1);
      cycles = 1;
      while (!done && cycles < 1000) begin
         @(negedge clk);
         cycles++;
         if (inject && cycles == 10) begin
            start = 1'b1; mem_kind = 2'd2; size_mb = SW'(524288);
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      chk(inject ? "R12 latency with ignored start" : "R11 latency", cycles, fe ? 2 : 130 + s);
      chk("R11 busy low at done", int'(busy), 0);
      chk("R2 fault flag", int'(fault), fe);
      chk("R3 R5 trim flag", int'(trim), fe ? 0 : te);
      @(negedge clk);
      chk("R11 done is one pulse", int'(done), 0);
      if (fe) begin
         if (have_img) begin
            for (int i = 0; i < 64; i += 21) begin
               read_byte(i, v);
               chk("R2 image untouched after reject", v, int'(last_img[i]));
            end
         end
         return;
      end
      sum = 0;
      for (int i = 0; i < 63; i++) begin
         read_byte(i, v);
         e = exp_byte(i, k, lg, b);
         sum += e;
         if (i == 2) tag = "R4 type code";
         else if (i == 5) tag = "R8 R5 R6 bank byte";
         else if (i == 31) tag = "R7 density";
         else tag = "R9 R13 fixed byte";
         chk(tag, v, e);
         last_img[i] = 8'(v);
      end
      read_byte(63, v);
      chk("R10 checksum", v, sum & 255);
      last_img[63] = 8'(v);
      have_img = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd7431));
      repeat (3) @(negedge clk);
      chk("R1 busy reset", int'(busy), 0);
      chk("R1 done reset", int'(done), 0);
      chk("R1 fault reset", int'(fault), 0);
      chk("R1 trim reset", int'(trim), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(0, 4, 0);           // R4 smallest legal single rate
      run(2, 3, 0);           // R2 below 4 MB
      run(1, 256, 0);         // R6 forced split
      run(3, 512, 0);         // R2 bad technology code
      run(2, 64, 0);          // R4 falls back to double rate
      run(1, 16, 0);          // R4 falls back to single rate
      run(0, 1000, 0);        // R3 truncation
      run(2, 524288, 0);      // R5 bank limit, capacity short
      run(2, 16384, 0);       // R5 exactly at maximum
      run(1, 32768, 0);       // R5 a few steps
      run(0, 48, 1);          // R12 start during build

      for (int t = 0; t < 40; t++) begin
         int lg, sz, kd;
         lg = $urandom_range(19, 0);
         sz = 1 << lg;
         if ($urandom_range(2, 0) != 0) sz = sz | ($urandom & ((1 << lg) - 1));
         kd = $urandom_range(3, 0);
         if (kd == 3 && $urandom_range(3, 0) != 0) kd = 2;
         run(kd, sz, 0);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule